// File: doc/BRIEF.md
# Bidirectional Timer Counter Core

This block is the counting heart of a 16-bit timer peripheral. It holds a count register that moves by one step on each qualified timer clock-enable pulse. On each such pulse it either clears to zero, counts up or counts down, and a direction input picks between up and down. A processor-side load port can overwrite the count at any time, including when the timer clock is switched off. A load always wins over a clear or count request in the same cycle.

The count is compared against two limits. The lower limit is zero. The upper limit is one of three fixed maxima (8-, 9- or 10-bit all-ones) or the value on one of two register inputs: a compare register or a capture register. The comparison results are output as the at-top and at-bottom flags. A sticky overflow flag marks a wrap at the top while counting up, or an arrival at zero while counting down, and software clears it with a write-one pulse. The clock-source selection, edge detection, waveform logic and byte-wide bus bridge are outside this block and appear here only as plain control inputs.

Top module: `tmr_count_core`

## Requirements
- R1: After reset `count` is 0x0000, `ovfFlag` is 0 and `atBottom` is 1.
- R2: When `loadEn` is 1 the count takes `loadVal` on that clock edge. This happens regardless of `runEn`, `tickEn`, `clearReq` or `countDown`, and no overflow is raised.
- R3: When `loadEn` is 0 and either `runEn` or `tickEn` is 0, the count holds its value.
- R4: A qualified step (`runEn`=1, `tickEn`=1, `loadEn`=0) with `clearReq`=1 sets the count to 0x0000 and does not raise overflow.
- R5: A qualified step without clear adds 1 when `countDown`=0 and subtracts 1 when `countDown`=1. Counting down from 0x0000 gives 0xFFFF.
- R6: `atTop` is 1 exactly when the count equals the selected top. The `topSel` encoding is: 0 selects 0x00FF, 1 selects 0x01FF, 2 selects 0x03FF, 3 selects `cmpA`, 4 selects `capVal`, and 5 to 7 select 0xFFFF.
- R7: `atBottom` is 1 exactly when the count is 0x0000.
- R8: A qualified up-step sets the count to 0x0000 in two cases: when the count is at the selected top and `wrapAtTop`=1, or when the count is 0xFFFF (regardless of `wrapAtTop`).
- R9: `ovfFlag` becomes 1 after a qualified up-step that wraps as in R8, and after a qualified down-step from 0x0001 to 0x0000.
- R10: `ovfFlag` stays set until `ovfClr` is pulsed. If a set event and `ovfClr` occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer clock-enable pulse |
| runEn | input | 1 | Clock source selected (0 stops counting) |
| countDown | input | 1 | Step direction, 1 = decrement |
| clearReq | input | 1 | Clear on the next qualified step |
| loadEn | input | 1 | Processor write strobe for the count |
| loadVal | input | 16 | Value written by the processor |
| topSel | input | 3 | Top value select (see R6) |
| wrapAtTop | input | 1 | Up-count wraps to zero at the top |
| cmpA | input | 16 | Compare register value |
| capVal | input | 16 | Capture register value |
| ovfClr | input | 1 | Write-one-to-clear for the overflow flag |
| count | output | 16 | Current count |
| atTop | output | 1 | Count equals the selected top |
| atBottom | output | 1 | Count equals zero |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume every control input is a clean synchronous level that is sampled once per clock, and they assume `tickEn` is a single-cycle strobe. Nothing else is assumed about how often `tickEn` arrives. The bench drives all inputs on the falling edge and holds them for one full cycle, so each rising edge sees one stable combination. The randomized phase deliberately produces loads that coincide with ticks, set events that coincide with `ovfClr`, and `cmpA`/`capVal` values that fall near the running count, so the wrap and top paths are exercised.

// File: rtl/tmr_count_pkg.sv
package tmr_count_pkg;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic doLoad;
    logic doClear;
    logic doInc;
    logic doDec;
    logic wrapZero;
  } cnt_strobe_t;
endpackage

// File: rtl/tmr_count_ctrl.sv
module tmr_count_ctrl
  import tmr_count_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        runEn,
  input  logic        countDown,
  input  logic        clearReq,
  input  logic        loadEn,
  input  logic        wrapAtTop,
  input  logic        ovfClr,
  input  logic        hitTop,
  input  logic        hitMax,
  input  logic        hitOne,
  output cnt_strobe_t strb,
  output logic        ovfFlag
);
  logic stepOk;
  logic setOvf;

  always_comb begin
    stepOk        = runEn & tickEn & ~loadEn;
    strb.doLoad   = loadEn;
    strb.doClear  = stepOk & clearReq;
    strb.doInc    = stepOk & ~clearReq & ~countDown;
    strb.doDec    = stepOk & ~clearReq & countDown;
    strb.wrapZero = strb.doInc & ((hitTop & wrapAtTop) | hitMax);
    setOvf        = strb.wrapZero | (strb.doDec & hitOne);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ovfFlag <= 1'b0;
    else if (setOvf) ovfFlag <= 1'b1;
    else if (ovfClr) ovfFlag <= 1'b0;
  end

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doDec && hitOne) |=> ovfFlag);
  // R10
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !strb.wrapZero && !(strb.doDec && hitOne)) |=> !ovfFlag);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doLoad, strb.doClear, strb.doInc, strb.doDec}));
endmodule

// File: rtl/tmr_count_dp.sv
module tmr_count_dp
  import tmr_count_pkg::*;
#(
  parameter int W      = CNT_W,
  parameter int FIX_LO = 8,
  parameter int FIX_MD = 9,
  parameter int FIX_HI = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  cnt_strobe_t  strb,
  input  logic [W-1:0] loadVal,
  input  logic [2:0]   topSel,
  input  logic [W-1:0] cmpA,
  input  logic [W-1:0] capVal,
  output logic [W-1:0] count,
  output logic         atTop,
  output logic         atBottom,
  output logic         hitMax,
  output logic         hitOne
);
  localparam int NFIX = 3;
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam int FIX_BITS [NFIX] = '{FIX_LO, FIX_MD, FIX_HI};

  logic [W-1:0] fixTop [NFIX];
  logic [W-1:0] topVal;
  logic [W-1:0] nextCnt;

  for (genvar g = 0; g < NFIX; g++) begin : g_fix
    assign fixTop[g] = ALL_ONES >> (W - FIX_BITS[g]);
  end

  always_comb begin
    unique case (topSel)
      3'd0:    topVal = fixTop[0];
      3'd1:    topVal = fixTop[1];
      3'd2:    topVal = fixTop[2];
      3'd3:    topVal = cmpA;
      3'd4:    topVal = capVal;
      default: topVal = ALL_ONES;
    endcase
  end

  always_comb begin
    atTop    = (count == topVal);
    atBottom = (count == '0);
    hitMax   = (count == ALL_ONES);
    hitOne   = (count == W'(1));
  end

  always_comb begin
    nextCnt = count;
    if (strb.doLoad)                          nextCnt = loadVal;
    else if (strb.doClear || strb.wrapZero)   nextCnt = '0;
    else if (strb.doInc)                      nextCnt = count + W'(1);
    else if (strb.doDec)                      nextCnt = count - W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else       count <= nextCnt;
  end

  // R2
  load_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doLoad |=> (count == $past(loadVal)));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.doLoad || strb.doClear || strb.doInc || strb.doDec) |=> $stable(count));
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doClear |=> atBottom);
  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrapZero |=> atBottom);
  // R5
  dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doDec |=> (count == $past(count) - W'(1)));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_count_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             runEn,
  input  logic             countDown,
  input  logic             clearReq,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [2:0]       topSel,
  input  logic             wrapAtTop,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] capVal,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] count,
  output logic             atTop,
  output logic             atBottom,
  output logic             ovfFlag
);
  cnt_strobe_t strb;
  logic hitMax;
  logic hitOne;

  tmr_count_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .runEn(runEn),
    .countDown(countDown), .clearReq(clearReq), .loadEn(loadEn),
    .wrapAtTop(wrapAtTop), .ovfClr(ovfClr), .hitTop(atTop),
    .hitMax(hitMax), .hitOne(hitOne), .strb(strb), .ovfFlag(ovfFlag)
  );

  tmr_count_dp #(.W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .topSel(topSel), .cmpA(cmpA), .capVal(capVal), .count(count),
    .atTop(atTop), .atBottom(atBottom), .hitMax(hitMax), .hitOne(hitOne)
  );
endmodule

// File: tb/tmr_count_core_tb.sv
module tmr_count_core_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 0, runEn = 1, countDown = 0, clearReq = 0, loadEn = 0;
  logic [15:0] loadVal = '0, cmpA = '0, capVal = '0;
  logic [2:0] topSel = '0;
  logic wrapAtTop = 1, ovfClr = 0;
  logic [15:0] count;
  logic atTop, atBottom, ovfFlag;

  int nChk = 0, nBad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_count_core u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .runEn(runEn),
    .countDown(countDown), .clearReq(clearReq), .loadEn(loadEn),
    .loadVal(loadVal), .topSel(topSel), .wrapAtTop(wrapAtTop),
    .cmpA(cmpA), .capVal(capVal), .ovfClr(ovfClr), .count(count),
    .atTop(atTop), .atBottom(atBottom), .ovfFlag(ovfFlag)
  );

  // {load, tick, clear, down, loadVal[15:0], expected count[15:0]}
  localparam int NV = 13;
  localparam logic [35:0] VEC [NV] = '{
    {4'b1000, 16'h00FD, 16'h00FD},  // R2 load
    {4'b0100, 16'h0000, 16'h00FE},  // R5 up
    {4'b0100, 16'h0000, 16'h00FF},  // R5 up to top
    {4'b0100, 16'h0000, 16'h0000},  // R8 wrap at top
    {4'b0101, 16'h0000, 16'hFFFF},  // R5 down from zero
    {4'b0100, 16'h0000, 16'h0000},  // R8 wrap at max
    {4'b1100, 16'h0002, 16'h0002},  // R2 load beats count
    {4'b0101, 16'h0000, 16'h0001},  // R5 down
    {4'b0101, 16'h0000, 16'h0000},  // R5 down to bottom
    {4'b0110, 16'h0000, 16'h0000},  // R4 clear
    {4'b0000, 16'h0000, 16'h0000},  // R3 no tick
    {4'b1000, 16'h1234, 16'h1234},  // R2 load
    {4'b0110, 16'h0000, 16'h0000}   // R4 clear
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic tk, input logic cl, input logic dn,
                       input logic [15:0] lv);
    loadEn = ld; tickEn = tk; clearReq = cl; countDown = dn; loadVal = lv;
    @(negedge clk);
  endtask

  // reference model state
  logic [15:0] mCnt = '0;
  logic mOvf = 1'b0;

  function automatic logic [15:0] topOf(input logic [2:0] s, input logic [15:0] a,
                                        input logic [15:0] c);
    case (s)
      3'd0: return 16'h00FF;
      3'd1: return 16'h01FF;
      3'd2: return 16'h03FF;
      3'd3: return a;
      3'd4: return c;
      default: return 16'hFFFF;
    endcase
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 16'h0000);
    chk("R1 ovf", {15'b0, ovfFlag}, 16'h0);
    chk("R7 bottom at reset", {15'b0, atBottom}, 16'h1);
    rstN = 1'b1;
    @(negedge clk);

    // table walk, topSel=0 (top 0x00FF), wrap enabled
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:16]);
      chk($sformatf("table row %0d", i), count, VEC[i][15:0]);
      if (i == 2) chk("R6 atTop 0x00FF", {15'b0, atTop}, 16'h1);
      if (i == 3) chk("R9 ovf on top wrap", {15'b0, ovfFlag}, 16'h1);
    end
    drive(0, 0, 0, 0, 0);

    // R10 clear ovf, then set wins over clear
    ovfClr = 1; drive(0, 0, 0, 0, 0); ovfClr = 0;
    chk("R10 ovf cleared", {15'b0, ovfFlag}, 16'h0);
    drive(1, 0, 0, 0, 16'h0001);
    ovfClr = 1; drive(0, 1, 0, 1, 0); ovfClr = 0;
    chk("R10 set wins", {15'b0, ovfFlag}, 16'h1);
    chk("R7 bottom", {15'b0, atBottom}, 16'h1);

    // R3 runEn low holds count, load still works
    runEn = 0;
    drive(0, 1, 0, 0, 0);
    chk("R3 hold when stopped", count, 16'h0000);
    drive(1, 1, 0, 0, 16'h0055);
    chk("R2 load while stopped", count, 16'h0055);
    runEn = 1;

    // R8 no wrap at top when disabled, R6 other fixed tops
    wrapAtTop = 0; topSel = 3'd1;
    drive(1, 0, 0, 0, 16'h01FF);
    chk("R6 atTop 0x01FF", {15'b0, atTop}, 16'h1);
    drive(0, 1, 0, 0, 0);
    chk("R8 pass top when wrap off", count, 16'h0200);
    topSel = 3'd2; drive(1, 0, 0, 0, 16'h03FF);
    chk("R6 atTop 0x03FF", {15'b0, atTop}, 16'h1);
    topSel = 3'd5; drive(1, 0, 0, 0, 16'hFFFF);
    chk("R6 atTop max sel", {15'b0, atTop}, 16'h1);
    ovfClr = 1; drive(0, 0, 0, 0, 0); ovfClr = 0;
    drive(0, 1, 0, 0, 0);
    chk("R8 max wraps with wrap off", count, 16'h0000);
    chk("R9 ovf on max wrap", {15'b0, ovfFlag}, 16'h1);
    wrapAtTop = 1;

    // randomized phase against reference model
    mCnt = count; mOvf = ovfFlag;
    for (int k = 0; k < 600; k++) begin
      logic ld, tk, cl, dn, rn, oc, wr, setE;
      logic [2:0] ts;
      logic [15:0] lv, tp, ca, cv;
      ld = ($urandom_range(0, 9) == 0);
      tk = ($urandom_range(0, 2) != 0);
      cl = ($urandom_range(0, 19) == 0);
      dn = ($urandom_range(0, 3) == 0);
      rn = ($urandom_range(0, 9) != 0);
      oc = ($urandom_range(0, 7) == 0);
      wr = ($urandom_range(0, 4) != 0);
      ts = 3'($urandom_range(0, 6));
      ca = mCnt + 16'($urandom_range(0, 4));
      cv = mCnt + 16'($urandom_range(0, 6));
      lv = ($urandom_range(0, 1) == 0) ? 16'($urandom) : 16'($urandom_range(0, 3));
      topSel = ts; wrapAtTop = wr; cmpA = ca; capVal = cv; runEn = rn; ovfClr = oc;
      tp = topOf(ts, ca, cv);
      setE = 1'b0;
      if (ld) mCnt = lv;
      else if (rn && tk) begin
        if (cl) mCnt = '0;
        else if (!dn) begin
          if ((mCnt == tp && wr) || mCnt == 16'hFFFF) begin mCnt = '0; setE = 1'b1; end
          else mCnt = mCnt + 16'd1;
        end else begin
          if (mCnt == 16'd1) setE = 1'b1;
          mCnt = mCnt - 16'd1;
        end
      end
      if (setE) mOvf = 1'b1; else if (oc) mOvf = 1'b0;
      drive(ld, tk, cl, dn, lv);
      chk("R5 random count", count, mCnt);
      chk("R9 random ovf", {15'b0, ovfFlag}, {15'b0, mOvf});
      chk("R6 random atTop", {15'b0, atTop}, {15'b0, (mCnt == tp)});
      chk("R7 random atBottom", {15'b0, atBottom}, {15'b0, (mCnt == 16'h0)});
    end
    ovfClr = 0; runEn = 1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule